// File: doc/BRIEF.md
# Multiply-then-Root Operation Sequencer

This block computes y = sqrt(a * b) on single-precision values by steering an external, multi-cycle floating-point unit. It does no arithmetic itself. A request on `go_i` captures both operands and the rounding mode. The block then launches a multiply on the unit and waits for the unit to report completion. It feeds the product back as the only operand of a square root and waits a second time. Finally it places the root on `y_o` and pulses `done_o`.

The unit launches an operation when it sees a one-cycle start pulse, and it raises `ready` when its result register holds the answer. That register keeps its value until the next start. The time to completion depends on the operation and is not fixed, so the sequencer counts no cycles and waits only on `ready`. The unit's ready output can still be high from the previous operation when a new one is launched. For this reason a completion counts only after `ready` has been seen low since the latest start pulse.

The controller has six states. Idle waits for a request. Mul-Go issues the multiply start. Mul-Wait holds the multiply operands until completion. Root-Go issues the square-root start. Root-Wait holds the root operand until completion. Done pulses the completion flag. The transitions are:
- Idle goes to Mul-Go on `go_i`.
- Mul-Go always goes to Mul-Wait.
- Mul-Wait goes to Root-Go on a qualified completion.
- Root-Go always goes to Root-Wait.
- Root-Wait goes to Done on a qualified completion.
- Done always goes to Idle.

Top module: `fmul_root_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `busy_o`, `done_o` and `fpu_start_o` are all 0.
- R2: A `go_i` seen in Idle causes, in the next cycle, `fpu_start_o`=1 with `fpu_op_o`=3'b010 (multiply), `fpu_opa_o`=a and `fpu_opb_o`=b.
- R3: Each start pulse lasts exactly one cycle. One computation issues exactly two start pulses.
- R4: Operands, opcode and rounding mode presented to the unit do not change from a start pulse until that operation's qualified completion.
- R5: A `fpu_ready_i` that is still high from an earlier operation is not taken as completion. Completion needs `fpu_ready_i` low at some cycle after the start pulse, followed by `fpu_ready_i` high.
- R6: The second operation uses `fpu_op_o`=3'b100 (square root), with `fpu_opa_o` equal to the multiply result captured at completion, and `fpu_opb_o`=0.
- R7: `y_o` equals the square-root result. `done_o` is high for exactly one cycle, and `y_o` holds its value afterwards until the next computation completes.
- R8: The 2-bit rounding mode (2'b00 = nearest-even; all four codes are passed through unchanged) is sampled at `go_i` and applied to both operations, regardless of later changes on `rmode_i`.
- R9: A `go_i` asserted while busy is ignored. It does not change operands, mode, or result, and it produces no extra computation.
- R10: The sequencer produces correct results for any unit latency of at least one cycle per operation, including different latencies for multiply and square root.
- R11: `busy_o` is high in every state except Idle, including the Done cycle. It is low in Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Request to compute sqrt(a*b) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| rmode_i | input | 2 | Rounding mode for both operations |
| y_o | output | 32 | Final result |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Computation in progress |
| fpu_start_o | output | 1 | Start pulse to the unit |
| fpu_opa_o | output | 32 | Operand A to the unit |
| fpu_opb_o | output | 32 | Operand B to the unit |
| fpu_op_o | output | 3 | Opcode to the unit |
| fpu_rmode_o | output | 2 | Rounding mode to the unit |
| fpu_res_i | input | 32 | Result register of the unit |
| fpu_ready_i | input | 1 | Completion flag of the unit |

## Verification
The bench runs the computation with several operand pairs and with every rounding code. It uses short and long multiply latencies against a 33-cycle root, which separates waiting on ready from counting a fixed delay. One pattern keeps the stand-in unit's ready high for an extra cycle after start, with a stale result. This pattern separates a sequencer that qualifies completion from one that samples the old result. Other patterns change `rmode_i` just after the request and pulse `go_i` mid-operation. These separate a design that captures at request time from one that forwards live inputs.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int unsigned FP_W  = 32;
    localparam int unsigned OPC_W = 3;
    localparam int unsigned RM_W  = 2;
    localparam logic [OPC_W-1:0] OPC_MUL  = 3'b010;
    localparam logic [OPC_W-1:0] OPC_ROOT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_GO,
        ST_MUL_WAIT,
        ST_ROOT_GO,
        ST_ROOT_WAIT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/fsq_ready_gate.sv
module fsq_ready_gate (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic waiting_i,
    input  logic ready_i,
    output logic complete_o
);
    logic armed_q;

    // Armed only after ready has been observed low following the latest start.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (issue_i) begin
            armed_q <= 1'b0;
        end else if (waiting_i && !ready_i) begin
            armed_q <= 1'b1;
        end
    end

    assign complete_o = waiting_i && ready_i && armed_q;

    // R5: the cycle right after a start can never count as completion
    p_no_stale_r5: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> !complete_o);
endmodule

// File: rtl/fsq_ctrl_fsm.sv
module fsq_ctrl_fsm
    import fsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       complete_i,
    output seq_state_e state_o,
    output logic       issue_o,
    output logic       waiting_o,
    output logic       root_phase_o,
    output logic       load_in_o,
    output logic       load_prod_o,
    output logic       load_res_o,
    output logic       busy_o,
    output logic       done_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go_i) state_d = ST_MUL_GO;
            ST_MUL_GO:    state_d = ST_MUL_WAIT;
            ST_MUL_WAIT:  if (complete_i) state_d = ST_ROOT_GO;
            ST_ROOT_GO:   state_d = ST_ROOT_WAIT;
            ST_ROOT_WAIT: if (complete_i) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        issue_o      = 1'b0;
        waiting_o    = 1'b0;
        root_phase_o = 1'b0;
        load_in_o    = 1'b0;
        load_prod_o  = 1'b0;
        load_res_o   = 1'b0;
        busy_o       = 1'b1;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                load_in_o = go_i;
            end
            ST_MUL_GO:   issue_o = 1'b1;
            ST_MUL_WAIT: begin
                waiting_o   = 1'b1;
                load_prod_o = complete_i;
            end
            ST_ROOT_GO: begin
                issue_o      = 1'b1;
                root_phase_o = 1'b1;
            end
            ST_ROOT_WAIT: begin
                waiting_o    = 1'b1;
                root_phase_o = 1'b1;
                load_res_o   = complete_i;
            end
            ST_DONE: begin
                root_phase_o = 1'b1;
                done_o       = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    p_start_one_r3: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> !issue_o);
    p_done_one_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
        (issue_o || waiting_o || done_o) |-> busy_o);
endmodule

// File: rtl/fsq_datapath.sv
module fsq_datapath #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OPC_W  = 3,
    parameter int unsigned RM_W   = 2,
    parameter logic [OPC_W-1:0] OPC_MUL  = 3'b010,
    parameter logic [OPC_W-1:0] OPC_ROOT = 3'b100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_in_i,
    input  logic              load_prod_i,
    input  logic              load_res_i,
    input  logic              root_phase_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [RM_W-1:0]   rm_i,
    input  logic [DATA_W-1:0] res_i,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o,
    output logic [OPC_W-1:0]  op_o,
    output logic [RM_W-1:0]   rm_o,
    output logic [DATA_W-1:0] y_o
);
    logic [DATA_W-1:0] a_q, b_q, prod_q, y_q;
    logic [RM_W-1:0]   rm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            rm_q <= '0;
        end else if (load_in_i) begin
            a_q  <= a_i;
            b_q  <= b_i;
            rm_q <= rm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              prod_q <= '0;
        else if (load_prod_i) prod_q <= res_i;
    end

    always_ff @(posedge clk) begin
        if (rst)             y_q <= '0;
        else if (load_res_i) y_q <= res_i;
    end

    always_comb begin
        if (root_phase_i) begin
            opa_o = prod_q;
            opb_o = '0;
            op_o  = OPC_ROOT;
        end else begin
            opa_o = a_q;
            opb_o = b_q;
            op_o  = OPC_MUL;
        end
    end

    assign rm_o = rm_q;
    assign y_o  = y_q;

    // R7: result register only moves at a root completion
    p_y_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load_res_i |=> $stable(y_q));
endmodule

// File: rtl/fmul_root_seq.sv
module fmul_root_seq
    import fsq_pkg::*;
#(
    parameter int unsigned DATA_W = FP_W,
    parameter int unsigned OPW    = OPC_W,
    parameter int unsigned RMW    = RM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [RMW-1:0]    rmode_i,
    output logic [DATA_W-1:0] y_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              fpu_start_o,
    output logic [DATA_W-1:0] fpu_opa_o,
    output logic [DATA_W-1:0] fpu_opb_o,
    output logic [OPW-1:0]    fpu_op_o,
    output logic [RMW-1:0]    fpu_rmode_o,
    input  logic [DATA_W-1:0] fpu_res_i,
    input  logic              fpu_ready_i
);
    seq_state_e state;
    logic issue, waiting, root_phase, load_in, load_prod, load_res, complete;

    fsq_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go_i),
        .complete_i  (complete),
        .state_o     (state),
        .issue_o     (issue),
        .waiting_o   (waiting),
        .root_phase_o(root_phase),
        .load_in_o   (load_in),
        .load_prod_o (load_prod),
        .load_res_o  (load_res),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    fsq_ready_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue),
        .waiting_i (waiting),
        .ready_i   (fpu_ready_i),
        .complete_o(complete)
    );

    fsq_datapath #(
        .DATA_W  (DATA_W),
        .OPC_W   (OPW),
        .RM_W    (RMW),
        .OPC_MUL (OPW'(OPC_MUL)),
        .OPC_ROOT(OPW'(OPC_ROOT))
    ) u_dp (
        .clk         (clk),
        .rst         (rst),
        .load_in_i   (load_in),
        .load_prod_i (load_prod),
        .load_res_i  (load_res),
        .root_phase_i(root_phase),
        .a_i         (a_i),
        .b_i         (b_i),
        .rm_i        (rmode_i),
        .res_i       (fpu_res_i),
        .opa_o       (fpu_opa_o),
        .opb_o       (fpu_opb_o),
        .op_o        (fpu_op_o),
        .rm_o        (fpu_rmode_o),
        .y_o         (y_o)
    );

    assign fpu_start_o = issue;

    // R4: operation inputs frozen while an operation is outstanding
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL_WAIT || state == ST_ROOT_WAIT)
        |-> ($stable(fpu_opa_o) && $stable(fpu_op_o) && $stable(fpu_rmode_o)));
    // R8 / R9: rounding mode cannot move once a computation is under way
    p_mode_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(fpu_rmode_o));
    // R11: idle means not busy
    p_idle_free_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !busy_o);
endmodule

// File: tb/fmul_root_seq_tb.sv
module fmul_root_seq_tb;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [1:0] rm = '0;
    logic [W-1:0] y, opa, opb, fres;
    logic done, busy, fstart, fready;
    logic [2:0] fop;
    logic [1:0] frm;

    always #4 clk = ~clk; // 125 MHz

    fmul_root_seq u_dut (
        .clk(clk), .rst(rst), .go_i(go), .a_i(a), .b_i(b), .rmode_i(rm),
        .y_o(y), .done_o(done), .busy_o(busy),
        .fpu_start_o(fstart), .fpu_opa_o(opa), .fpu_opb_o(opb),
        .fpu_op_o(fop), .fpu_rmode_o(frm),
        .fpu_res_i(fres), .fpu_ready_i(fready)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stand-in arithmetic (not real floating point)
    function automatic logic [W-1:0] f_mul(logic [W-1:0] x, logic [W-1:0] z, logic [1:0] m);
        return (x * z) ^ {30'd0, m};
    endfunction
    function automatic logic [W-1:0] f_root(logic [W-1:0] x, logic [1:0] m);
        return {x[15:0], x[31:16]} + {30'd0, m} + 32'h0101_0000;
    endfunction

    // ---------------- latency-accurate unit stand-in ----------------
    int mul_lat = 5, root_lat = 33;
    bit late_drop = 1'b0;
    int cnt = 0;
    bit m_busy = 1'b0, drop_pend = 1'b0, prev_start = 1'b0;
    logic [W-1:0] c_opa, c_opb;
    logic [2:0] c_op;
    logic [1:0] c_rm;
    int n_start = 0, n_hold_err = 0, n_pulse_err = 0, n_b_err = 0;

    always @(posedge clk) begin
        prev_start <= fstart;
        if (rst) begin
            fready <= 1'b1;
            fres   <= 32'hDEAD_BEEF;
            m_busy <= 1'b0;
            drop_pend <= 1'b0;
        end else if (fstart) begin
            if (prev_start) n_pulse_err++;
            n_start++;
            c_opa <= opa; c_opb <= opb; c_op <= fop; c_rm <= frm;
            if (fop == 3'b100 && opb !== '0) n_b_err++;
            cnt <= (fop == 3'b010) ? mul_lat : root_lat;
            m_busy <= 1'b1;
            if (late_drop) drop_pend <= 1'b1;
            else           fready <= 1'b0;
        end else if (m_busy) begin
            if (opa !== c_opa || fop !== c_op || frm !== c_rm) n_hold_err++;
            if (drop_pend) begin
                fready <= 1'b0;
                drop_pend <= 1'b0;
            end
            if (cnt <= 1) begin
                fready <= 1'b1;
                fres   <= (c_op == 3'b010) ? f_mul(c_opa, c_opb, c_rm) : f_root(c_opa, c_rm);
                m_busy <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [W-1:0] exp_q[$];
    bit prev_done = 1'b0;
    int n_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                n_done++;
                if (prev_done) chk("R7 done width", 32'd2, 32'd1);
                if (exp_q.size() == 0) chk("R9 unexpected result", 32'd1, 32'd0);
                else chk("R7 result", y, exp_q.pop_front());
                chk("R11 busy in done", {31'd0, busy}, 32'd1);
            end
            prev_done <= done;
        end
    end

    // ---------------- driver ----------------
    task automatic compute(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic [1:0] xm,
                           input int ml, input int rl, input bit stale, input bit poke);
        logic [W-1:0] yk;
        int s0;
        mul_lat = ml; root_lat = rl; late_drop = stale;
        s0 = n_start;
        exp_q.push_back(f_root(f_mul(xa, xb, xm), xm));
        @(negedge clk);
        go = 1'b1; a = xa; b = xb; rm = xm;
        @(negedge clk);
        go = 1'b0;
        chk("R2 start", {31'd0, fstart}, 32'd1);
        chk("R2 opcode mul", {29'd0, fop}, 32'd2);
        chk("R2 opa", opa, xa);
        chk("R2 opb", opb, xb);
        chk("R11 busy", {31'd0, busy}, 32'd1);
        rm = ~xm;                      // R8: late change must not matter
        if (poke) begin                // R9: request while busy
            go = 1'b1; a = ~xa; b = xb + 1;
            @(negedge clk);
            go = 1'b0;
            chk("R9 opa unchanged", opa, xa);
        end
        // wait for the root launch and check its operand (R6)
        while (!(fstart && fop == 3'b100)) @(negedge clk);
        chk("R6 root opa", opa, f_mul(xa, xb, xm));
        chk("R6 root opb", opb, '0);
        chk("R8 root mode", {30'd0, frm}, {30'd0, xm});
        while (busy) @(negedge clk);
        chk("R11 idle", {31'd0, busy}, 32'd0);
        chk("R3 two starts", n_start - s0, 32'd2);
        yk = y;
        repeat (3) @(negedge clk);
        chk("R7 hold", y, yk);
        chk("R9 no extra op", {31'd0, busy}, 32'd0);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk("R1 start in reset", {31'd0, fstart}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 start", {31'd0, fstart}, 32'd0);

        compute(32'h4120_0000, 32'h0000_0003, 2'b00, 5, 33, 1'b0, 1'b0);   // R10 nominal
        compute(32'h1234_5678, 32'h9ABC_DEF1, 2'b01, 1, 33, 1'b0, 1'b0);   // R10 shortest
        compute(32'hFFFF_FFFF, 32'h0000_0002, 2'b10, 40, 2, 1'b0, 1'b0);   // R10 swapped lengths
        compute(32'h0F0F_0F0F, 32'h0000_0011, 2'b11, 4, 33, 1'b1, 1'b0);   // R5 stale ready
        compute(32'h0000_0007, 32'h0000_0009, 2'b10, 12, 33, 1'b0, 1'b1);  // R9 poke
        compute(32'hCAFE_0001, 32'h0000_0005, 2'b01, 3, 7, 1'b1, 1'b1);    // R5 + R9

        chk("R4 operands held", n_hold_err, 0);
        chk("R3 single-cycle start", n_pulse_err, 0);
        chk("R6 root opb zero", n_b_err, 0);
        chk("R7 one done per op", n_done, 6);
        chk("R9 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule